// File: doc/BRIEF.md
# Byte-Level Two-Wire Bus Master

This block is a master engine for a two-wire serial bus (one clock line, one data line, both open-drain and wired-AND). Software builds each transfer one byte at a time. A single command word says whether to generate a start condition, whether to shift a byte out or in, which acknowledge level to return after a read, and whether to finish with a stop condition. The block carries out exactly those actions and then reports the outcome. The outcome is a done flag, the acknowledge the slave returned, an arbitration-lost flag, and an optional level interrupt. To address a slave with a 10-bit address, software issues two write commands after the start instead of one.

Bit timing comes from an external quarter-bit strobe. The block splits every bit into four quarters and changes the data line only while the clock is low. When it releases the clock line, it holds its own sequence until the line is actually seen high. A slave that stretches the clock, or another master with a longer low period, therefore lengthens the bit. Every bit the block drives is checked against the bus. If a released (high) bit reads back low at the high clock phase, another master has won. The block then lets go of both lines, flags the loss and raises the interrupt.

Top module: `twm_byte_master`

## Requirements
- R1: A command with the start bit set makes the data line fall while the clock line is high, after which the block holds the clock line low and keeps the bus until a stop.
- R2: A write command shifts the transmit byte out most significant bit first, changing the data line only while the clock line is low, so no start or stop condition appears during the byte.
- R3: On a write, the ninth clock samples the slave: `ack_rcvd` becomes 1 if the data line was low on that clock and 0 if it was high.
- R4: A read command shifts in eight bits, most significant first, and places them in `rx_byte` at the end of the byte. On the ninth clock it pulls the data line low when `cmd_nack` is 0 and releases it when `cmd_nack` is 1. If read and write are both set, write takes precedence.
- R5: A command with the stop bit set ends with the data line rising while the clock line is high. After the stop, both lines are released (`scl_oe` = `sda_oe` = 0).
- R6: `busy` rises only in the cycle after an accepted command and falls when the start, byte, acknowledge and any stop are complete. At that point `done` or `arb_lost` is set. All three status flags are cleared when the next command is accepted.
- R7: A command presented while `busy` is 1 is ignored: it changes neither the byte on the bus nor the stop action, and no second transfer follows.
- R8: If the block releases the data line for a bit it drives but samples it low at the high clock phase, it sets `arb_lost`, releases both lines, returns to idle and does not set `done`. This applies to data bits as well as acknowledge bits.
- R9: `irq` is set by a completion while `irq_en` is 1, and by any arbitration loss regardless of `irq_en`. It stays set until `irq_clear` is 1 in a cycle with no new setting event; a set event wins over a clear in the same cycle.
- R10: After releasing the clock line, the block waits until the clock line reads high before it starts counting the high period. A clock held low by another device therefore still gets a full high phase of at least one quarter strobe period.
- R11: Byte commands issued back to back without start or stop keep the clock line held low between bytes and produce no start or stop condition. This is how the two bytes of a 10-bit address are sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qtr_tick | input | 1 | Quarter-bit strobe from the bus clock generator |
| cmd_valid | input | 1 | Command write strobe |
| cmd_start | input | 1 | Generate a start (or repeated start) first |
| cmd_stop | input | 1 | Generate a stop at the end |
| cmd_read | input | 1 | Receive one byte |
| cmd_write | input | 1 | Send the transmit byte |
| cmd_nack | input | 1 | Acknowledge level sent after a read: 0 pulls low, 1 releases |
| tx_byte | input | DATA_W | Transmit buffer |
| irq_en | input | 1 | Let completions raise the interrupt |
| irq_clear | input | 1 | Write-one-to-clear for the interrupt |
| scl_in | input | 1 | Sensed clock line level |
| sda_in | input | 1 | Sensed data line level |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| rx_byte | output | DATA_W | Receive buffer, last completed read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed normally |
| ack_rcvd | output | 1 | Slave acknowledged the last written byte |
| arb_lost | output | 1 | Last transfer lost arbitration |
| irq | output | 1 | Level interrupt |

## Verification
The completion of a transfer and a software clear of the interrupt can land on the same clock edge. The bench holds `irq_clear` high for the whole of a write with `irq_en` set. It drops the clear on the first cycle in which `done` is seen, and then expects `irq` to still read 1, because the set must win. A command arriving while a transfer is under way is a second overlap. The bench sends a stop-carrying write a few cycles into a running byte and checks that the bus shows the original byte, no stop, and no follow-on transfer.

// File: rtl/twm_pkg.sv
`timescale 1ns/1ps
package twm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_BIT   = 2'd2,
      ST_STOP  = 2'd3
   } twm_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rd;
      logic wr;
      logic nack;
   } twm_cmd_t;
endpackage

// File: rtl/twm_seq.sv
`timescale 1ns/1ps
module twm_seq
   import twm_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     qtr_tick,
   input  logic     scl_in,
   input  logic     sda_in,
   input  logic     cmd_go,
   input  twm_cmd_t cmd_in,
   input  logic     tx_msb,
   output logic     busy,
   output logic     scl_oe,
   output logic     sda_oe,
   output logic     shift_en,
   output logic     last_data,
   output logic     smp_bit,
   output logic     rd_active,
   output logic     ack_vld,
   output logic     ack_ok,
   output logic     done_evt,
   output logic     arb_evt
);
   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(DATA_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   twm_state_e       state_q;
   logic [1:0]       phase_q;
   logic [IDX_W-1:0] idx_q;
   twm_cmd_t         cmd_q;
   logic             own_q;
   logic             smp_q;

   logic hold, step, is_ack, bit_val, drives;
   logic in_bit, ph2, ph3;

   // Variant: wait for the clock line to read high before the high phase
   generate
      if (STRETCH_EN) begin : g_stretch
         assign hold = (phase_q == 2'd1) && !scl_in;
      end else begin : g_free
         assign hold = 1'b0;
      end
   endgenerate

   assign step    = qtr_tick && !hold && (state_q != ST_IDLE);
   assign in_bit  = (state_q == ST_BIT);
   assign ph2     = step && (phase_q == 2'd2);
   assign ph3     = step && (phase_q == 2'd3);
   assign is_ack  = (idx_q == ACK_IDX);
   assign bit_val = cmd_q.wr ? (is_ack ? 1'b1 : tx_msb) : (is_ack ? cmd_q.nack : 1'b1);
   assign drives  = cmd_q.wr ? !is_ack : is_ack;

   assign arb_evt   = in_bit && ph2 && drives && bit_val && !sda_in;
   assign shift_en  = in_bit && ph3 && !is_ack;
   assign last_data = (idx_q == LAST_IDX);
   assign smp_bit   = smp_q;
   assign rd_active = cmd_q.rd;
   assign ack_vld   = in_bit && ph2 && is_ack && cmd_q.wr;
   assign ack_ok    = !sda_in;
   assign busy      = (state_q != ST_IDLE);

   assign done_evt = ph3 && (
         ((state_q == ST_START) && !cmd_q.rd && !cmd_q.wr && !cmd_q.stop) ||
         (in_bit && is_ack && !cmd_q.stop) ||
         (state_q == ST_STOP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= 2'd0;
         idx_q   <= '0;
         cmd_q   <= '0;
         own_q   <= 1'b0;
         smp_q   <= 1'b0;
      end else if (cmd_go) begin
         state_q <= cmd_in.start ? ST_START :
                    (cmd_in.rd || cmd_in.wr) ? ST_BIT : ST_STOP;
         phase_q <= 2'd0;
         idx_q   <= '0;
         cmd_q   <= cmd_in;
      end else if (arb_evt) begin
         state_q <= ST_IDLE;
         phase_q <= 2'd0;
         own_q   <= 1'b0;
      end else if (step) begin
         phase_q <= phase_q + 2'd1;
         if (phase_q == 2'd2) smp_q <= sda_in;
         if (phase_q == 2'd3) begin
            case (state_q)
               ST_START: begin
                  own_q   <= 1'b1;
                  idx_q   <= '0;
                  state_q <= (cmd_q.rd || cmd_q.wr) ? ST_BIT :
                             cmd_q.stop ? ST_STOP : ST_IDLE;
               end
               ST_BIT: begin
                  if (is_ack) state_q <= cmd_q.stop ? ST_STOP : ST_IDLE;
                  else        idx_q   <= idx_q + 1'b1;
               end
               ST_STOP: begin
                  own_q   <= 1'b0;
                  state_q <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      case (state_q)
         ST_IDLE: begin
            scl_oe = own_q;
         end
         ST_START: begin
            case (phase_q)
               2'd0:    begin scl_oe = own_q; sda_oe = 1'b0; end
               2'd1:    begin scl_oe = 1'b0;  sda_oe = 1'b0; end
               2'd2:    begin scl_oe = 1'b0;  sda_oe = 1'b1; end
               default: begin scl_oe = 1'b1;  sda_oe = 1'b1; end
            endcase
         end
         ST_BIT: begin
            scl_oe = (phase_q == 2'd0) || (phase_q == 2'd3);
            sda_oe = !bit_val;
         end
         default: begin
            scl_oe = (phase_q == 2'd0);
            sda_oe = (phase_q == 2'd0) || (phase_q == 2'd1);
         end
      endcase
   end
endmodule

// File: rtl/twm_shift.sv
`timescale 1ns/1ps
module twm_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              shift_en,
   input  logic              smp_bit,
   input  logic              last_data,
   input  logic              rd_active,
   output logic              tx_msb,
   output logic [DATA_W-1:0] rx_byte
);
   logic [DATA_W-1:0] tx_q, rx_q, rx_buf_q;
   logic [DATA_W-1:0] rx_next;

   assign rx_next = {rx_q[DATA_W-2:0], smp_bit};
   assign tx_msb  = tx_q[DATA_W-1];
   assign rx_byte = rx_buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q     <= '0;
         rx_q     <= '0;
         rx_buf_q <= '0;
      end else begin
         if (load)          tx_q <= tx_byte;
         else if (shift_en) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
         if (shift_en) begin
            rx_q <= rx_next;
            if (last_data && rd_active) rx_buf_q <= rx_next;
         end
      end
   end
endmodule

// File: rtl/twm_status.sv
`timescale 1ns/1ps
module twm_status (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_go,
   input  logic done_evt,
   input  logic arb_evt,
   input  logic ack_vld,
   input  logic ack_ok,
   input  logic irq_en,
   input  logic irq_clear,
   output logic done,
   output logic ack_rcvd,
   output logic arb_lost,
   output logic irq
);
   logic irq_set;
   assign irq_set = (done_evt && irq_en) || arb_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         ack_rcvd <= 1'b0;
         arb_lost <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (cmd_go) begin
            done     <= 1'b0;
            ack_rcvd <= 1'b0;
            arb_lost <= 1'b0;
         end else begin
            if (done_evt) done     <= 1'b1;
            if (arb_evt)  arb_lost <= 1'b1;
            if (ack_vld)  ack_rcvd <= ack_ok;
         end
         if (irq_set)        irq <= 1'b1;
         else if (irq_clear) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/twm_byte_master.sv
`timescale 1ns/1ps
module twm_byte_master
   import twm_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qtr_tick,
   input  logic              cmd_valid,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_read,
   input  logic              cmd_write,
   input  logic              cmd_nack,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              irq_en,
   input  logic              irq_clear,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic [DATA_W-1:0] rx_byte,
   output logic              busy,
   output logic              done,
   output logic              ack_rcvd,
   output logic              arb_lost,
   output logic              irq
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("twm_byte_master: DATA_W must be at least 2");
      end
   endgenerate

   twm_cmd_t cmd_w;
   logic cmd_go, tx_msb, shift_en, last_data, smp_bit, rd_active;
   logic ack_vld, ack_ok, done_evt, arb_evt;

   // Write wins when both transfer directions are requested
   assign cmd_w.start = cmd_start;
   assign cmd_w.stop  = cmd_stop;
   assign cmd_w.wr    = cmd_write;
   assign cmd_w.rd    = cmd_read && !cmd_write;
   assign cmd_w.nack  = cmd_nack;

   assign cmd_go = cmd_valid && !busy &&
                   (cmd_start || cmd_stop || cmd_read || cmd_write);

   twm_seq #(.DATA_W(DATA_W), .STRETCH_EN(STRETCH_EN)) u_seq (
      .clk(clk), .rst_n(rst_n), .qtr_tick(qtr_tick),
      .scl_in(scl_in), .sda_in(sda_in),
      .cmd_go(cmd_go), .cmd_in(cmd_w), .tx_msb(tx_msb),
      .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .shift_en(shift_en), .last_data(last_data), .smp_bit(smp_bit),
      .rd_active(rd_active), .ack_vld(ack_vld), .ack_ok(ack_ok),
      .done_evt(done_evt), .arb_evt(arb_evt)
   );

   twm_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(cmd_go), .tx_byte(tx_byte),
      .shift_en(shift_en), .smp_bit(smp_bit), .last_data(last_data),
      .rd_active(rd_active), .tx_msb(tx_msb), .rx_byte(rx_byte)
   );

   twm_status u_status (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go),
      .done_evt(done_evt), .arb_evt(arb_evt),
      .ack_vld(ack_vld), .ack_ok(ack_ok),
      .irq_en(irq_en), .irq_clear(irq_clear),
      .done(done), .ack_rcvd(ack_rcvd), .arb_lost(arb_lost), .irq(irq)
   );
endmodule

// File: rtl/twm_byte_master_chk.sv
`timescale 1ns/1ps
module twm_byte_master_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic busy,
   input logic done,
   input logic arb_lost,
   input logic irq,
   input logic scl_oe,
   input logic sda_oe
);
   assert_busy_needs_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   assert_finish_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || arb_lost));

   assert_loss_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> (!scl_oe && !sda_oe && !busy));

   assert_loss_interrupts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> irq);

   assert_irq_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (done || arb_lost));
endmodule

bind twm_byte_master twm_byte_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
   .done(done), .arb_lost(arb_lost), .irq(irq),
   .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/twm_byte_master_test.sv
`timescale 1ns/1ps
module twm_byte_master_test;
   logic clk = 1'b0, rst_n = 1'b0, qtr_tick = 1'b0;
   logic cmd_valid = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
   logic cmd_read = 1'b0, cmd_write = 1'b0, cmd_nack = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic irq_en = 1'b0, irq_clear = 1'b0;
   logic scl_oe, sda_oe, busy, done, ack_rcvd, arb_lost, irq;
   logic [7:0] rx_byte;
   logic sl_low = 1'b0, rival_low = 1'b0, stretch = 1'b0;
   wire scl_in = !(scl_oe || stretch);
   wire sda_in = !(sda_oe || sl_low || rival_low);

   int n_run = 0, n_fail = 0, n_start = 0, n_stop = 0, n_rise = 0;
   int cyc = 0, hi_cyc = 0;
   logic [1:0] tdiv = 2'd0;

   twm_byte_master uut (
      .clk(clk), .rst_n(rst_n), .qtr_tick(qtr_tick),
      .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cmd_read(cmd_read), .cmd_write(cmd_write), .cmd_nack(cmd_nack),
      .tx_byte(tx_byte), .irq_en(irq_en), .irq_clear(irq_clear),
      .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .rx_byte(rx_byte), .busy(busy), .done(done), .ack_rcvd(ack_rcvd),
      .arb_lost(arb_lost), .irq(irq)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      tdiv     <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
      qtr_tick <= (tdiv == 2'd2);
   end
   always @(negedge sda_in) if (scl_in) n_start++;
   always @(posedge sda_in) if (scl_in) n_stop++;
   always @(posedge scl_in) n_rise++;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input bit st, input bit sp, input bit rd, input bit wr,
                        input bit nk, input logic [7:0] b);
      @(negedge clk);
      cmd_start = st; cmd_stop = sp; cmd_read = rd; cmd_write = wr;
      cmd_nack = nk; tx_byte = b; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic xfer(input bit st, input bit sp, input bit rd, input bit wr,
                       input bit nk, input logic [7:0] b, input logic [7:0] sbyte,
                       input bit sack, input int sbit, input bit spam,
                       output logic [7:0] seen, output logic seen9);
      logic [8:0] bits;
      int t0;
      bits = '0;
      t0 = 0;
      fork
         begin
            issue(st, sp, rd, wr, nk, b);
            if (spam) begin
               repeat (6) @(negedge clk);
               issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
            end
         end
         begin
            if (st) begin
               wait (scl_in == 1'b1);
               @(negedge scl_in);
            end
            if (rd || wr) begin
               for (int i = 0; i < 9; i++) begin
                  if (i < 8) sl_low = wr ? 1'b0 : !sbyte[7-i];
                  else       sl_low = wr ? sack : 1'b0;
                  if (i == sbit) begin
                     stretch = 1'b1;
                     repeat (20) @(posedge clk);
                     stretch = 1'b0;
                  end
                  @(posedge scl_in);
                  t0 = cyc;
                  bits[8-i] = sda_in;
                  @(negedge scl_in);
                  if (i == sbit) hi_cyc = cyc - t0;
               end
            end
            sl_low = 1'b0;
         end
      join
      @(negedge clk);
      while (busy) @(negedge clk);
      seen  = bits[8:1];
      seen9 = bits[0];
   endtask

   task automatic t_reset();
      chk("R6", "busy after reset", busy, 0);
      chk("R5", "scl_oe after reset", scl_oe, 0);
      chk("R5", "sda_oe after reset", sda_oe, 0);
      chk("R9", "irq after reset", irq, 0);
   endtask

   task automatic t_addr_write();
      logic [7:0] s; logic a; int s0, p0;
      s0 = n_start; p0 = n_stop;
      xfer(1, 0, 0, 1, 0, 8'hA6, 8'h00, 1, -1, 0, s, a);
      chk("R1", "start count", n_start - s0, 1);
      chk("R1", "clock held after start", scl_oe, 1);
      chk("R2", "byte on bus", s, 8'hA6);
      chk("R2", "no stop during byte", n_stop - p0, 0);
      chk("R3", "ack_rcvd on ack", ack_rcvd, 1);
      chk("R6", "done after write", done, 1);
   endtask

   task automatic t_second_addr();
      logic [7:0] s; logic a; int s0, p0;
      s0 = n_start; p0 = n_stop;
      xfer(0, 0, 0, 1, 0, 8'h3C, 8'h00, 0, -1, 0, s, a);
      chk("R11", "no start between bytes", n_start - s0, 0);
      chk("R11", "no stop between bytes", n_stop - p0, 0);
      chk("R11", "clock still held", scl_oe, 1);
      chk("R2", "second byte on bus", s, 8'h3C);
      chk("R3", "ack_rcvd on nack", ack_rcvd, 0);
   endtask

   task automatic t_read_ack();
      logic [7:0] s; logic a; int s0;
      s0 = n_start;
      xfer(1, 0, 1, 0, 0, 8'h00, 8'h5B, 0, -1, 0, s, a);
      chk("R1", "repeated start", n_start - s0, 1);
      chk("R4", "rx_byte", rx_byte, 8'h5B);
      chk("R4", "ninth bit ack low", a, 0);
   endtask

   task automatic t_read_nack_stop();
      logic [7:0] s; logic a; int p0;
      p0 = n_stop;
      xfer(0, 1, 1, 0, 1, 8'h00, 8'hC3, 0, -1, 0, s, a);
      chk("R4", "rx_byte", rx_byte, 8'hC3);
      chk("R4", "ninth bit nack high", a, 1);
      chk("R5", "stop count", n_stop - p0, 1);
      chk("R5", "scl released", scl_oe, 0);
      chk("R5", "sda released", sda_oe, 0);
   endtask

   task automatic t_ignore_busy();
      logic [7:0] s; logic a; int p0;
      irq_en = 1'b0;
      p0 = n_stop;
      xfer(1, 0, 0, 1, 0, 8'h81, 8'h00, 1, -1, 1, s, a);
      chk("R7", "byte kept", s, 8'h81);
      chk("R7", "no stop from ignored cmd", n_stop - p0, 0);
      chk("R7", "clock still held", scl_oe, 1);
      repeat (30) @(negedge clk);
      chk("R7", "no follow-on transfer", busy, 0);
      chk("R9", "no irq with irq_en low", irq, 0);
   endtask

   task automatic t_irq_overlap();
      logic [7:0] s; logic a;
      irq_en = 1'b1;
      fork
         xfer(0, 0, 0, 1, 0, 8'h44, 8'h00, 1, -1, 0, s, a);
         begin
            irq_clear = 1'b1;
            @(negedge clk);
            while (!busy) @(negedge clk);
            while (!done) @(negedge clk);
            irq_clear = 1'b0;
         end
      join
      chk("R9", "set wins over clear", irq, 1);
      @(negedge clk) irq_clear = 1'b1;
      @(negedge clk) irq_clear = 1'b0;
      chk("R9", "cleared by irq_clear", irq, 0);
      irq_en = 1'b0;
   endtask

   task automatic t_stretch();
      logic [7:0] s; logic a;
      hi_cyc = 0;
      xfer(0, 0, 0, 1, 0, 8'h99, 8'h00, 1, 3, 0, s, a);
      chk("R10", "byte under stretch", s, 8'h99);
      chk("R10", "full high after stretch", (hi_cyc >= 3) ? 1 : 0, 1);
   endtask

   task automatic t_arb();
      int r0;
      @(negedge clk) rival_low = 1'b1;
      r0 = n_rise;
      issue(0, 0, 0, 1, 0, 8'h0F);
      chk("R6", "busy after accept", busy, 1);
      while (busy) @(negedge clk);
      chk("R8", "arb_lost", arb_lost, 1);
      chk("R8", "no done on loss", done, 0);
      chk("R8", "lost on fifth bit", n_rise - r0, 5);
      chk("R8", "scl released", scl_oe, 0);
      chk("R8", "sda released", sda_oe, 0);
      chk("R9", "irq on loss with irq_en low", irq, 1);
      rival_low = 1'b0;
      @(negedge clk) irq_clear = 1'b1;
      @(negedge clk) irq_clear = 1'b0;
   endtask

   task automatic t_recover();
      logic [7:0] s; logic a; int p0;
      p0 = n_stop;
      xfer(1, 1, 0, 1, 0, 8'h12, 8'h00, 1, -1, 0, s, a);
      chk("R6", "arb_lost cleared by new cmd", arb_lost, 0);
      chk("R6", "done after recovery", done, 1);
      chk("R2", "byte after recovery", s, 8'h12);
      chk("R5", "stop after recovery", n_stop - p0, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_write();
      t_second_addr();
      t_read_ack();
      t_read_nack_stop();
      t_ignore_busy();
      t_irq_overlap();
      t_stretch();
      t_arb();
      t_recover();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule